// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is a synchronous I2C target that puts a small byte-addressed register array on a two-wire bus, in the manner of a serial EEPROM. A fast system clock oversamples the open-drain clock and data lines. A bus master selects the target with a seven-bit device address. The upper four bits of that address are a fixed device code. The lower three bits are taken from strap inputs, so up to eight such targets can share one bus.

A write transfer carries two word-pointer bytes, high byte first, followed by any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read transfer sends bytes from the current pointer for as long as the master acknowledges them. To do a random read, the master writes the pointer and then issues a repeated START with the read bit set.

The block drives only an SDA pull-down enable and a busy flag.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is asserted and after it is released, `sda_pull_o` is 0 and `busy_o` is 0.
- R2: While idle, the target ignores every clock and data activity that is not a START (SDA falling while SCL is high). `busy_o` stays 0 and SDA is never pulled.
- R3: The first byte after a START is received MSB first. Its bits 7..4 must equal 4'b1010 and its bits 3..1 must equal `strap_i`. On a mismatch the target leaves SDA released during the ninth clock (NACK) and returns to idle, with `busy_o` low.
- R4: When a write is selected (bit 0 = 0), the target pulls SDA low during the ninth clock of the address byte and of every following byte.
- R5: The two bytes after a write address set the word pointer, high byte first. Only the low `MEM_AW` bits of the 16-bit value are kept, so the upper bits of the high byte are ignored.
- R6: Each later write byte is stored at the pointer. The pointer then increments modulo 2^`MEM_AW`.
- R7: When a read is selected (bit 0 = 1), the target ACKs the address and then sends the byte at the pointer MSB first. It increments the pointer after each byte and sends the next byte only when the master pulls SDA low in the ninth clock.
- R8: After the master NACKs a read byte, the target releases SDA and ignores everything, including a START, until a STOP.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle: `busy_o` goes low and SDA is released.
- R10: A repeated START in the middle of a transfer restarts address matching without a STOP, and the word pointer is kept.
- R11: `sda_pull_o` changes only while SCL is low.
- R12: `busy_o` is 1 from a START until the target next becomes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Device select bits compared with address bits 3..1 |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Target is inside a transfer |

## Verification
The checker watches four things on every cycle, using the synchronized line samples. The pull-down changes only while the clock is low. A START always leaves the target busy. A STOP always returns it to idle. The idle state is left only through a START, and SDA is never pulled while idle.

Some behaviour can only be shown by the bench's bus scenarios. These cover ACK and NACK on address match and mismatch, pointer loading with the ignored high bits, wrap-around of writes and sequential reads, random and current-address reads through a repeated START, and the silence after a master NACK until a STOP.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int          MEM_AW   = 9,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o,
  output logic       busy_o
);
  // MEM_AW must lie in 9..13
  localparam int DEPTH = 1 << MEM_AW;
  localparam int HI_W  = MEM_AW - 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_PTRH, ST_PTRL, ST_WDAT, ST_RDAT, ST_HOLD
  } st_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_s, sda_s, scl_p, sda_p;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic [HI_W-1:0]   ptr_hi;
  logic [MEM_AW-1:0] ptr;
  logic       pull, rd_mode, mack;
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s = scl_ff[1];
  assign sda_s = sda_ff[1];

  wire start_c   = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c    = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire byte_done = scl_fall && (cnt == 4'd8);
  wire ack_end   = scl_fall && (cnt == 4'd9);
  wire addr_hit  = (sh[7:1] == {DEV_CODE, strap_i});
  wire mem_we    = !start_c && !stop_c && (state == ST_WDAT) && byte_done;

  assign rd_byte    = mem[ptr];
  assign sda_pull_o = pull;
  assign busy_o     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr_hi  <= '0;
      ptr     <= '0;
      pull    <= 1'b0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
    end else if (stop_c) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (start_c && state != ST_HOLD) begin
      state <= ST_DEV;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (state == ST_IDLE || state == ST_HOLD) begin
      cnt <= '0;
    end else if (state == ST_RDAT) begin
      if (scl_rise && cnt < 4'd8) begin
        cnt <= cnt + 4'd1;
      end else if (scl_rise && cnt == 4'd8) begin
        mack <= ~sda_s;
        cnt  <= 4'd9;
      end else if (scl_fall && cnt >= 4'd1 && cnt <= 4'd7) begin
        tx   <= {tx[5:0], 1'b0};
        pull <= ~tx[6];
      end else if (byte_done) begin
        pull <= 1'b0;
      end else if (ack_end) begin
        if (mack) begin
          tx   <= rd_byte[6:0];
          pull <= ~rd_byte[7];
          ptr  <= ptr + 1'b1;
          cnt  <= '0;
        end else begin
          state <= ST_HOLD;
          pull  <= 1'b0;
          cnt   <= '0;
        end
      end
    end else begin
      if (scl_rise && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (byte_done) begin
        cnt  <= 4'd9;
        pull <= 1'b1;
        case (state)
          ST_DEV: begin
            if (!addr_hit) begin
              state <= ST_IDLE;
              pull  <= 1'b0;
              cnt   <= '0;
            end
            rd_mode <= sh[0];
          end
          ST_PTRH: ptr_hi <= sh[HI_W-1:0];
          ST_PTRL: ptr    <= {ptr_hi, sh};
          ST_WDAT: ptr    <= ptr + 1'b1;
          default: ;
        endcase
      end else if (ack_end) begin
        cnt  <= '0;
        pull <= 1'b0;
        case (state)
          ST_DEV: begin
            if (rd_mode) begin
              state <= ST_RDAT;
              tx    <= rd_byte[6:0];
              pull  <= ~rd_byte[7];
              ptr   <= ptr + 1'b1;
            end else begin
              state <= ST_PTRH;
            end
          end
          ST_PTRH: state <= ST_PTRL;
          ST_PTRL: state <= ST_WDAT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_s,
  input logic sda_pull_o,
  input logic busy_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  wire start_seen = scl_q & scl_s & sda_q & ~sda_s;
  wire stop_seen  = scl_q & scl_s & ~sda_q & sda_s;

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) || $fell(sda_pull_o)) |-> !scl_s); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> busy_o); // R12
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!busy_o && !sda_pull_o)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sda_pull_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_seen) |=> !busy_o); // R2
endmodule

bind i2c_mem_target i2c_mem_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
  .sda_pull_o(sda_pull_o), .busy_o(busy_o)
);

// File: tb/i2c_mem_target_tb_top.sv
module i2c_mem_target_tb_top;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_o, busy_o;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;

  i2c_mem_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_pull_o(sda_pull_o), .busy_o(busy_o)
  );

  int checks = 0;
  int errors = 0;
  int pull_cycles = 0;
  int high_changes = 0;
  logic pull_d = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always @(posedge clk) begin
    if (sda_pull_o) pull_cycles <= pull_cycles + 1;
    if (sda_pull_o !== pull_d && scl_m) high_changes <= high_changes + 1;
    pull_d <= sda_pull_o;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    repeat (3) @(negedge clk);
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      repeat (3) @(negedge clk);
      sda_m = b[i]; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
    end
    repeat (3) @(negedge clk);
    sda_m = 1'b1; half();
    scl_m = 1'b1;
    repeat (Q/2) @(negedge clk);
    ack = ~sda_line;
    repeat (Q/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      repeat (3) @(negedge clk);
      half();
      scl_m = 1'b1;
      repeat (Q/2) @(negedge clk);
      b[i] = sda_line;
      repeat (Q/2) @(negedge clk);
      scl_m = 1'b0;
    end
    repeat (3) @(negedge clk);
    sda_m = ~mack; half();
    scl_m = 1'b1; half();
    scl_m = 1'b0;
    repeat (3) @(negedge clk);
    sda_m = 1'b1;
  endtask

  // driver side: expected item goes in before the bus operation
  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    exp_q.push_back({7'd0, exp_ack});
    tag_q.push_back({tag, " ack"});
    put_byte(b, a);
    obs_q.push_back({7'd0, a});
  endtask

  task automatic recv(input logic [7:0] exp, input bit mack, input string tag);
    logic [7:0] v;
    exp_q.push_back(exp);
    tag_q.push_back({tag, " read byte"});
    get_byte(v, mack);
    obs_q.push_back(v);
  endtask

  // monitor side
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(o === e, t, "scoreboard", int'(o), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pc;
    repeat (5) @(negedge clk);
    check(sda_pull_o === 1'b0, "R1", "pull in reset", int'(sda_pull_o), 0);
    check(busy_o === 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_pull_o === 1'b0 && busy_o === 1'b0, "R1", "outputs after reset",
          int'({sda_pull_o, busy_o}), 0);

    // R2: clocked traffic with no START
    pc = pull_cycles;
    scl_m = 1'b0; half();
    send(8'hAA, 1'b0, "R2");
    check(busy_o === 1'b0, "R2", "busy without start", int'(busy_o), 0);
    check(pull_cycles == pc, "R2", "pull cycles without start", pull_cycles, pc);

    // write 3 bytes at 0x1FE with wrap (high byte 0xFF keeps bit 0 only)
    bus_start();
    repeat (6) @(negedge clk);
    check(busy_o === 1'b1, "R12", "busy after start", int'(busy_o), 1);
    send(8'hAA, 1'b1, "R3");
    send(8'hFF, 1'b1, "R5");
    send(8'hFE, 1'b1, "R5");
    send(8'h11, 1'b1, "R4");
    send(8'h22, 1'b1, "R6");
    send(8'h33, 1'b1, "R6");
    check(busy_o === 1'b1, "R12", "busy during write", int'(busy_o), 1);
    bus_stop();
    repeat (5) @(negedge clk);
    check(busy_o === 1'b0, "R9", "busy after stop", int'(busy_o), 0);

    // random read across the wrap via repeated START
    bus_start();
    send(8'hAA, 1'b1, "R3");
    send(8'h01, 1'b1, "R5");
    send(8'hFE, 1'b1, "R5");
    bus_start();
    send(8'hAB, 1'b1, "R10");
    recv(8'h11, 1'b1, "R7");
    recv(8'h22, 1'b1, "R7");
    recv(8'h33, 1'b0, "R6");
    pc = pull_cycles;
    bus_start();
    send(8'hAB, 1'b0, "R8");
    check(pull_cycles == pc, "R8", "pull after master nack", pull_cycles, pc);
    check(busy_o === 1'b1, "R8", "still waiting for stop", int'(busy_o), 1);
    bus_stop();
    repeat (5) @(negedge clk);
    check(busy_o === 1'b0, "R9", "busy after stop", int'(busy_o), 0);

    // address mismatch: strap 001 instead of 101
    bus_start();
    send(8'hA2, 1'b0, "R3");
    repeat (5) @(negedge clk);
    check(busy_o === 1'b0, "R3", "idle after mismatch", int'(busy_o), 0);
    send(8'hAA, 1'b0, "R3");
    bus_stop();

    // pointer 0x040 with ignored high bits, then current-address read
    bus_start();
    send(8'hAA, 1'b1, "R4");
    send(8'hF0, 1'b1, "R5");
    send(8'h40, 1'b1, "R5");
    send(8'h5A, 1'b1, "R6");
    send(8'hC3, 1'b1, "R6");
    bus_stop();
    bus_start();
    send(8'hAA, 1'b1, "R4");
    send(8'hF0, 1'b1, "R5");
    send(8'h40, 1'b1, "R5");
    bus_stop();
    bus_start();
    send(8'hAB, 1'b1, "R7");
    recv(8'h5A, 1'b1, "R5");
    recv(8'hC3, 1'b0, "R7");
    bus_stop();
    repeat (5) @(negedge clk);
    check(busy_o === 1'b0 && sda_pull_o === 1'b0, "R9", "final idle",
          int'({busy_o, sda_pull_o}), 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
    check(high_changes == 0, "R11", "pull changes with scl high", high_changes, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule